// File: doc/BRIEF.md
# Either-Edge Event Status and SMI Routing Registers

This block is a small bank of byte-wide registers on a simple register bus (address, write strobe, read strobe, write data, read data). It watches six asynchronous general-purpose event inputs. Each input is synchronised, and any change of level, rising or falling, latches a sticky status bit. Software clears a status bit by writing a one to its position.

A separate 8-bit enable mask selects which of eight level sources may assert a shared active-low SMI line. Four general-purpose levels sit in mask bits 3:0 and two tachometer monitor levels sit in bits 7:6. Mask bits 5:4 are holes: they cannot be set and they read as zero. The sources behind the mask arrive as plain level inputs. Reads are combinational while the read strobe is high.

Top module: `evt_smi_regs`

## Requirements
- R1: The enable mask is at address 0x1A and reads 0x00 after reset. A write to 0x1A stores the data, and a read of 0x1A returns it in the same cycle.
- R2: Enable bits 5:4 are reserved. Writing ones to them is ignored, and they always read as zero.
- R3: Addresses 0x1B, 0x1D and every other address apart from 0x1A and 0x1C read as 0x00. Writes to these addresses change no register.
- R4: The status register is at address 0x1C and reads 0x00 after reset. A rising edge on evt_in[i] (i = 0..5) sets status bit i.
- R5: A falling edge on evt_in[i] also sets status bit i.
- R6: Writing 1 to status bit i (bits 5:0) clears it. Writing 0 to a bit leaves it unchanged.
- R7: Status bits 7:6 always read as zero.
- R8: When an edge and a write-1-clear of the same bit fall in the same cycle, the bit ends up set.
- R9: smi_n is low exactly when some source is high and its enable bit is set. The source map is gp_src[3:0] to mask bits 3:0 and tach_src[1:0] to mask bits 7:6.
- R10: An input change that is applied before rising clock edge k becomes visible in the status register after rising edge k+2. It passes through two synchroniser flops and then the status flop.
- R11: reg_rdata is 0x00 whenever reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high |
| evt_in | input | 6 | Asynchronous either-edge event inputs |
| gp_src | input | 4 | General-purpose SMI source levels |
| tach_src | input | 2 | Tachometer monitor SMI source levels |
| smi_n | output | 1 | Shared active-low SMI output |

## Verification
The assertions check four things on every cycle. A synchronised edge always leaves its status bit set one cycle later, even when a clear arrives in the same cycle. A status bit never rises without an edge. A clear with no competing edge empties the bit. Unmapped or idle reads return zero. The bench scenarios are needed to show the properties that span the whole path: the exact three-edge latency from pin to status, the behaviour on both edge directions, the source-to-mask bit map behind smi_n, and the way mask holes and reserved addresses resist writes.

// File: rtl/evt_smi_pkg.sv
// Shared constants for the event status / SMI routing register bank.
// Assumes a byte-wide register bus with 8-bit addresses.
package evt_smi_pkg;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned N_EVT    = 6;
    localparam int unsigned N_GP     = 4;
    localparam int unsigned N_TACH   = 2;
    localparam int unsigned N_HOLE   = DATA_W - N_GP - N_TACH;
    localparam logic [ADDR_W-1:0] ADDR_EN  = 8'h1A;
    localparam logic [ADDR_W-1:0] ADDR_STS = 8'h1C;
    // Writable enable positions: GP bits low, tach bits high, holes between.
    localparam logic [DATA_W-1:0] EN_MASK  =
        {{N_TACH{1'b1}}, {N_HOLE{1'b0}}, {N_GP{1'b1}}};
endpackage

// File: rtl/evt_sync_edge.sv
// Two-flop synchroniser per input followed by a change detector.
// Assumes async_in may change at any time; chg pulses one cycle per level change.
module evt_sync_edge #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] chg
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic s1, s2, prev;
            // Resample the pin twice, then keep one older copy for the compare.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1   <= 1'b0;
                    s2   <= 1'b0;
                    prev <= 1'b0;
                end else begin
                    s1   <= async_in[g];
                    s2   <= s1;
                    prev <= s2;
                end
            end
            // A difference between the new and the old sample marks an edge.
            assign chg[g] = s2 ^ prev;
        end
    endgenerate
endmodule

// File: rtl/evt_status_bank.sv
// Sticky status bits set by edge pulses and cleared by a write-one request.
// Assumes clr is already qualified by the write strobe and address; set beats clear.
module evt_status_bank #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] chg,
    input  logic [W-1:0] clr,
    output logic [W-1:0] sts
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            // Update one sticky bit; an edge takes priority over a clear.
            always_ff @(posedge clk) begin
                if (!rst_n)        sts[g] <= 1'b0;
                else if (chg[g])   sts[g] <= 1'b1;
                else if (clr[g])   sts[g] <= 1'b0;
            end

            assert_edge_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
                chg[g] |=> sts[g]);
            assert_no_spurious_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (!chg[g] && !sts[g]) |=> !sts[g]);
            assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[g] && !chg[g]) |=> !sts[g]);
        end
    endgenerate
endmodule

// File: rtl/smi_route.sv
// Gates each level source by its enable bit and merges them onto one active-low line.
// Assumes sources are synchronous levels; no latching is applied.
module smi_route #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] en,
    input  logic [W-1:0] src,
    output logic         smi_n
);
    // Any enabled, asserted source pulls the shared line low.
    always_comb smi_n = ~|(en & src);
endmodule

// File: rtl/evt_smi_regs.sv
// Register bank top: enable mask, edge status, reserved decode and SMI output.
// Assumes one-cycle write strobes; reads are combinational while reg_rd is high.
module evt_smi_regs
    import evt_smi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_EVT-1:0]  evt_in,
    input  logic [N_GP-1:0]   gp_src,
    input  logic [N_TACH-1:0] tach_src,
    output logic              smi_n
);
    logic [DATA_W-1:0] en_q;
    logic [N_EVT-1:0]  chg, sts, clr;
    logic              hit_en, hit_sts;

    assign hit_en  = (reg_addr == ADDR_EN);
    assign hit_sts = (reg_addr == ADDR_STS);

    // Hold the enable mask; hole positions can never be written.
    always_ff @(posedge clk) begin
        if (!rst_n)               en_q <= '0;
        else if (reg_wr && hit_en) en_q <= reg_wdata & EN_MASK;
    end

    // Turn a status write into per-bit clear requests.
    always_comb clr = (reg_wr && hit_sts) ? reg_wdata[N_EVT-1:0] : '0;

    evt_sync_edge #(.W(N_EVT)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(evt_in), .chg(chg)
    );

    evt_status_bank #(.W(N_EVT)) u_sts (
        .clk(clk), .rst_n(rst_n), .chg(chg), .clr(clr), .sts(sts)
    );

    smi_route #(.W(DATA_W)) u_smi (
        .en(en_q), .src({tach_src, {N_HOLE{1'b0}}, gp_src}), .smi_n(smi_n)
    );

    // Read mux: two mapped offsets, zero everywhere else and when idle.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (hit_en)       reg_rdata = en_q;
            else if (hit_sts) reg_rdata = {{(DATA_W-N_EVT){1'b0}}, sts};
        end
    end

    assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> reg_rdata == '0);
    assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !hit_en && !hit_sts) |-> reg_rdata == '0);
    assert_holes_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_en) |=> en_q[N_GP+N_HOLE-1:N_GP] == '0);
    assert_en_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_en) |=> en_q[N_GP-1:0] == $past(reg_wdata[N_GP-1:0]));
    assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && hit_en) |=> $stable(en_q));
endmodule

// File: tb/test_evt_smi_regs.sv
module test_evt_smi_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [5:0] evt_in = '0;
    logic [3:0] gp_src = '0;
    logic [1:0] tach_src = '0;
    logic       smi_n;
    int total = 0, bad = 0, cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    evt_smi_regs i_evt_smi_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_in(evt_in), .gp_src(gp_src), .tach_src(tach_src), .smi_n(smi_n)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            bad++; total++;
            $display("FAIL watchdog: act=%0d exp<=20000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
    endtask

    // {address, write data, expected readback}
    localparam logic [23:0] VEC [8] = '{
        {8'h1A, 8'hFF, 8'hCF},   // R1 R2
        {8'h1A, 8'h30, 8'h00},   // R2 holes only
        {8'h1B, 8'hFF, 8'h00},   // R3
        {8'h1D, 8'hAA, 8'h00},   // R3
        {8'h1A, 8'h5A, 8'h4A},   // R1 R2
        {8'h1C, 8'hFF, 8'h00},   // R6 R7
        {8'h00, 8'hFF, 8'h00},   // R3
        {8'h1A, 8'h00, 8'h00}    // R1
    };

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        rd(8'h1A, d); chk("R1 reset", d, 8'h00);
        rd(8'h1C, d); chk("R4 reset", d, 8'h00);
        chk("R9 reset smi", {7'b0, smi_n}, 8'h01);

        foreach (VEC[i]) begin
            wr(VEC[i][23:16], VEC[i][15:8]);
            rd(VEC[i][23:16], d);
            chk("R1/R2/R3 vector", d, VEC[i][7:0]);
        end

        // R3: reserved write leaves enable untouched
        wr(8'h1A, 8'h03); wr(8'h1B, 8'hFF); wr(8'h1D, 8'hFF);
        rd(8'h1A, d); chk("R3 reserved write", d, 8'h03);
        // R11: idle read
        @(negedge clk); reg_addr = 8'h1A; #1 chk("R11 idle rdata", reg_rdata, 8'h00);
        wr(8'h1A, 8'h00);

        // R10: latency, R4 rising
        @(negedge clk) evt_in[0] = 1'b1;          // before edge k
        @(posedge clk); @(posedge clk); #1;      // after k+1
        reg_addr = 8'h1C; reg_rd = 1'b1; #1 chk("R10 not yet", reg_rdata, 8'h00);
        @(posedge clk); #1 chk("R10 after k+2 / R4", reg_rdata, 8'h01);
        reg_rd = 1'b0;
        // R6: write 0 no effect, write 1 clears
        wr(8'h1C, 8'h00); rd(8'h1C, d); chk("R6 write zero", d, 8'h01);
        wr(8'h1C, 8'h01); rd(8'h1C, d); chk("R6 clear", d, 8'h00);
        // R5 falling edge
        @(negedge clk) evt_in[0] = 1'b0; settle();
        rd(8'h1C, d); chk("R5 falling", d, 8'h01);
        // R4 several bits at once; R7 upper bits stay zero
        @(negedge clk) evt_in[5:1] = 5'b10110; settle();
        rd(8'h1C, d); chk("R4 multi", d, 8'h2D);
        wr(8'h1C, 8'hC5); rd(8'h1C, d); chk("R6/R7 partial clear", d, 8'h28);
        wr(8'h1C, 8'hFF); rd(8'h1C, d); chk("R7 cleared", d, 8'h00);

        // R8: set first, then edge coincident with clear
        @(negedge clk) evt_in[2] = 1'b1; settle();
        @(negedge clk) evt_in[2] = 1'b0;
        @(posedge clk); @(posedge clk);
        wr(8'h1C, 8'h04);
        rd(8'h1C, d); chk("R8 set wins", d, 8'h04);
        wr(8'h1C, 8'h04); rd(8'h1C, d); chk("R8 later clear", d, 8'h00);

        // R9 gating and bit map
        @(negedge clk) gp_src = 4'b0001; #1 chk("R9 disabled", {7'b0, smi_n}, 8'h01);
        wr(8'h1A, 8'h01); #1 chk("R9 gp0 enabled", {7'b0, smi_n}, 8'h00);
        @(negedge clk) gp_src = 4'b1110; #1 chk("R9 other gp masked", {7'b0, smi_n}, 8'h01);
        @(negedge clk) gp_src = 4'b0000; tach_src = 2'b10;
        wr(8'h1A, 8'h40); #1 chk("R9 tach1 masked", {7'b0, smi_n}, 8'h01);
        wr(8'h1A, 8'h80); #1 chk("R9 tach2 bit7", {7'b0, smi_n}, 8'h00);
        wr(8'h1A, 8'h30); #1 chk("R2 holes no smi", {7'b0, smi_n}, 8'h01);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule